// File: doc/BRIEF.md
# Centralized Synchronization Request Shell

This block is a small register shell that sits beside a hardware task in a system where one central processor performs all FIFO synchronization on behalf of the tasks. When the task needs a synchronization call, it hands the shell a two-bit call code and a channel index. The shell stores both, clears its result register to zero and raises a service request toward the processor. The request is either a one-cycle pulse on a direct interrupt line, or a one-cycle bus write that carries the shell's own task index toward a remote signal register.

The processor reads the call code and channel index through a memory-mapped port. Once the call can be honoured, it writes the result register. A result of zero means the call is still pending. Any non-zero value ends the call: for a claim it is the pointer to the granted token, and for a release it is a fixed acknowledge value. The shell stays busy from the moment it accepts a call until that non-zero write arrives, and it refuses new calls while busy. The notification style and the task index are held in a configuration register.

Top module: `sync_req_shell`

## Requirements
- R1: After reset, task_busy is 0, task_result is 0, notify_irq and notify_sig_wr are 0, cpu_rdata is 0, the notification mode is direct and the task index is 0.
- R2: When task_req is high and the shell is idle, the call code and channel index are stored, the result register becomes 0, and task_busy reads 1 from the following cycle.
- R3: While task_busy is 1, task_req is refused: the stored call code and channel index are unchanged and no notification is produced.
- R4: In direct mode (configuration bit 0 = 0), accepting a call makes notify_irq 1 for exactly the one cycle after the accepting edge, and notify_sig_wr stays 0.
- R5: In signal mode (configuration bit 0 = 1), accepting a call makes notify_sig_wr 1 for exactly one cycle after the accepting edge, with notify_sig_data equal to the configured task index, and notify_irq stays 0.
- R6: A processor write of zero to the result register (address 2) while busy leaves task_busy at 1 and task_result at 0.
- R7: A processor write of a non-zero value V to the result register while busy makes task_result equal to V and task_busy 0 from the following cycle.
- R8: A processor write to the result register while the shell is idle is ignored, and task_result keeps its value.
- R9: A processor read returns its data on cpu_rdata one cycle after cpu_rd. Address 0 returns the call code in bits [1:0], where 00 is claim data, 01 is claim space, 10 is release data and 11 is release space. Address 1 returns the channel index, address 2 returns the result, and address 3 returns the configuration word. All unused upper bits read as 0.
- R10: A processor write to address 3 sets the mode from bit 0 and the task index from bits [TID_W:1]. The new values apply to the next accepted call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| task_req | input | 1 | Task asks for a synchronization call |
| task_op | input | 2 | Call code of the request |
| task_chan | input | CH_W | Channel index of the request |
| task_busy | output | 1 | A call is outstanding |
| task_result | output | PTR_W | Result register: 0 while pending, otherwise token pointer or acknowledge |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_addr | input | 2 | Register address |
| cpu_wdata | input | PTR_W | Processor write data |
| cpu_rdata | output | PTR_W | Registered processor read data |
| notify_irq | output | 1 | Direct interrupt pulse |
| notify_sig_wr | output | 1 | Strobe of the write toward the remote signal register |
| notify_sig_data | output | TID_W | Task index carried by that write |

## Verification
Assertions check the following on every cycle:
- the busy and zero-result state that follows an accepted call;
- the frozen call code and channel index while busy;
- the completion that follows a non-zero result write;
- a result that cannot change while idle;
- at most one notification kind, and only on the cycle after an accepted call.

Only the bench scenarios can show the rest: the exact register values returned through the read port for each call code, that a configuration change takes effect at the next call, that the carried task index is the configured one, and that a zero write does not end a call.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic [1:0] {
    CALL_CLAIM_DATA    = 2'b00,
    CALL_CLAIM_SPACE   = 2'b01,
    CALL_RELEASE_DATA  = 2'b10,
    CALL_RELEASE_SPACE = 2'b11
  } call_e;

  typedef enum logic {
    NOTE_DIRECT = 1'b0,
    NOTE_SIGNAL = 1'b1
  } note_e;

  localparam logic [1:0] REG_CALL   = 2'd0;
  localparam logic [1:0] REG_CHAN   = 2'd1;
  localparam logic [1:0] REG_RESULT = 2'd2;
  localparam logic [1:0] REG_CFG    = 2'd3;
endpackage

// File: rtl/srs_call_regs.sv
module srs_call_regs
  import srs_pkg::*;
#(
  parameter int CH_W  = 4,
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  call_e            op,
  input  logic [CH_W-1:0]  chan,
  input  logic             res_we,
  input  logic [PTR_W-1:0] res_wdata,
  output logic             accept,
  output logic             busy,
  output call_e            op_q,
  output logic [CH_W-1:0]  chan_q,
  output logic [PTR_W-1:0] result_q
);
  logic finish;

  assign accept = req && !busy;
  assign finish = busy && res_we && (res_wdata != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      op_q     <= CALL_CLAIM_DATA;
      chan_q   <= '0;
      result_q <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      op_q     <= op;
      chan_q   <= chan;
      result_q <= '0;
    end else if (finish) begin
      busy     <= 1'b0;
      result_q <= res_wdata;
    end
  end

  assert_accept_loads_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> (busy && result_q == '0 && op_q == $past(op) && chan_q == $past(chan)));

  assert_refused_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(op_q) && $stable(chan_q)));

  assert_zero_keeps_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && res_we && res_wdata == '0) |=> (busy && result_q == '0));

  assert_nonzero_completes_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && res_we && res_wdata != '0) |=> (!busy && result_q == $past(res_wdata)));

  assert_idle_result_held_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !req) |=> $stable(result_q));
endmodule

// File: rtl/srs_cfg_regs.sv
module srs_cfg_regs
  import srs_pkg::*;
#(
  parameter int TID_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [TID_W:0]   cfg_wdata,
  output note_e            mode,
  output logic [TID_W-1:0] tid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= NOTE_DIRECT;
      tid  <= '0;
    end else if (cfg_we) begin
      mode <= note_e'(cfg_wdata[0]);
      tid  <= cfg_wdata[TID_W:1];
    end
  end

  assert_cfg_load_R10: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (tid == $past(cfg_wdata[TID_W:1])));
endmodule

// File: rtl/srs_notifier.sv
module srs_notifier
  import srs_pkg::*;
#(
  parameter int TID_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  note_e            mode,
  input  logic [TID_W-1:0] tid,
  output logic             irq,
  output logic             sig_wr,
  output logic [TID_W-1:0] sig_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq      <= 1'b0;
      sig_wr   <= 1'b0;
      sig_data <= '0;
    end else begin
      irq    <= accept && (mode == NOTE_DIRECT);
      sig_wr <= accept && (mode == NOTE_SIGNAL);
      if (accept) sig_data <= tid;
    end
  end

  assert_one_kind_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({irq, sig_wr}));

  assert_note_after_accept_R5: assert property (@(posedge clk) disable iff (rst)
    (irq || sig_wr) |-> $past(accept));
endmodule

// File: rtl/sync_req_shell.sv
module sync_req_shell
  import srs_pkg::*;
#(
  parameter int CH_W  = 4,
  parameter int PTR_W = 16,
  parameter int TID_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             task_req,
  input  logic [1:0]       task_op,
  input  logic [CH_W-1:0]  task_chan,
  output logic             task_busy,
  output logic [PTR_W-1:0] task_result,
  input  logic             cpu_wr,
  input  logic             cpu_rd,
  input  logic [1:0]       cpu_addr,
  input  logic [PTR_W-1:0] cpu_wdata,
  output logic [PTR_W-1:0] cpu_rdata,
  output logic             notify_irq,
  output logic             notify_sig_wr,
  output logic [TID_W-1:0] notify_sig_data
);
  localparam int CFG_W = TID_W + 1;

  logic             accept;
  call_e            op_q;
  logic [CH_W-1:0]  chan_q;
  note_e            mode;
  logic [TID_W-1:0] tid;
  logic             res_we;
  logic             cfg_we;
  logic [PTR_W-1:0] rd_mux;

  assign res_we = cpu_wr && (cpu_addr == REG_RESULT);
  assign cfg_we = cpu_wr && (cpu_addr == REG_CFG);

  srs_call_regs #(.CH_W(CH_W), .PTR_W(PTR_W)) u_call (
    .clk(clk), .rst(rst), .req(task_req), .op(call_e'(task_op)), .chan(task_chan),
    .res_we(res_we), .res_wdata(cpu_wdata), .accept(accept), .busy(task_busy),
    .op_q(op_q), .chan_q(chan_q), .result_q(task_result)
  );

  srs_cfg_regs #(.TID_W(TID_W)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cpu_wdata[CFG_W-1:0]),
    .mode(mode), .tid(tid)
  );

  srs_notifier #(.TID_W(TID_W)) u_note (
    .clk(clk), .rst(rst), .accept(accept), .mode(mode), .tid(tid),
    .irq(notify_irq), .sig_wr(notify_sig_wr), .sig_data(notify_sig_data)
  );

  always_comb begin
    case (cpu_addr)
      REG_CALL:   rd_mux = {{(PTR_W-2){1'b0}}, op_q};
      REG_CHAN:   rd_mux = {{(PTR_W-CH_W){1'b0}}, chan_q};
      REG_RESULT: rd_mux = task_result;
      default:    rd_mux = {{(PTR_W-CFG_W){1'b0}}, tid, mode};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         cpu_rdata <= '0;
    else if (cpu_rd) cpu_rdata <= rd_mux;
  end

  assert_read_held_R9: assert property (@(posedge clk) disable iff (rst)
    !cpu_rd |=> $stable(cpu_rdata));
endmodule

// File: tb/sync_req_shell_bench.sv
module sync_req_shell_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CH_W = 4, PTR_W = 16, TID_W = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic task_req = 1'b0;
  logic [1:0] task_op = '0;
  logic [CH_W-1:0] task_chan = '0;
  logic task_busy;
  logic [PTR_W-1:0] task_result;
  logic cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [1:0] cpu_addr = '0;
  logic [PTR_W-1:0] cpu_wdata = '0;
  logic [PTR_W-1:0] cpu_rdata;
  logic notify_irq, notify_sig_wr;
  logic [TID_W-1:0] notify_sig_data;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_req_shell #(.CH_W(CH_W), .PTR_W(PTR_W), .TID_W(TID_W)) u_sync_req_shell (
    .clk(clk), .rst(rst), .task_req(task_req), .task_op(task_op), .task_chan(task_chan),
    .task_busy(task_busy), .task_result(task_result), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .notify_irq(notify_irq), .notify_sig_wr(notify_sig_wr), .notify_sig_data(notify_sig_data)
  );

  function automatic logic [PTR_W-1:0] cfg_word(logic m, logic [TID_W-1:0] t);
    return PTR_W'({t, m});
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cpu_write(logic [1:0] a, logic [PTR_W-1:0] d);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    step();
    cpu_wr = 1'b0;
  endtask

  task automatic cpu_read_chk(string r, logic [1:0] a, logic [PTR_W-1:0] exp);
    cpu_rd = 1'b1; cpu_addr = a;
    step();
    cpu_rd = 1'b0;
    chk(r, cpu_rdata, exp);
  endtask

  task automatic issue(logic [1:0] op, logic [CH_W-1:0] ch);
    task_req = 1'b1; task_op = op; task_chan = ch;
    step();
    task_req = 1'b0;
  endtask

  task automatic one_call(logic m, logic [TID_W-1:0] t, logic [1:0] op,
                          logic [CH_W-1:0] ch, logic [PTR_W-1:0] ptr, bit zero_first);
    cpu_write(2'd3, cfg_word(m, t));
    issue(op, ch);
    chk("R2 busy", task_busy, 1);
    chk("R2 result zero", task_result, 0);
    chk("R4 irq", notify_irq, !m);
    chk("R5 sig_wr", notify_sig_wr, m);
    if (m) chk("R5 sig_data", notify_sig_data, t);
    issue(~op, ~ch);
    chk("R3 no irq", notify_irq, 0);
    chk("R3 no sig", notify_sig_wr, 0);
    cpu_read_chk("R9 call reg", 2'd0, PTR_W'(op));
    cpu_read_chk("R9 chan reg", 2'd1, PTR_W'(ch));
    cpu_read_chk("R9 cfg reg", 2'd3, cfg_word(m, t));
    if (zero_first) begin
      cpu_write(2'd2, '0);
      chk("R6 busy", task_busy, 1);
      chk("R6 result", task_result, 0);
    end
    cpu_write(2'd2, ptr);
    chk("R7 busy", task_busy, 0);
    chk("R7 result", task_result, ptr);
    cpu_read_chk("R9 result reg", 2'd2, ptr);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    repeat (3) step();
    rst = 1'b0;
    chk("R1 busy", task_busy, 0);
    chk("R1 result", task_result, 0);
    chk("R1 irq", notify_irq, 0);
    chk("R1 sig", notify_sig_wr, 0);
    chk("R1 rdata", cpu_rdata, 0);
    cpu_read_chk("R1 cfg", 2'd3, 0);

    cpu_write(2'd2, 16'h0055);
    chk("R8 idle write ignored", task_result, 0);
    chk("R8 still idle", task_busy, 0);

    // R10 directed: direct mode, index 5, release data (2'b10) on channel 7
    cpu_write(2'd3, cfg_word(1'b0, 4'd5));
    cpu_read_chk("R10 cfg readback", 2'd3, 16'd10);
    issue(2'b10, 4'd7);
    chk("R4 irq pulse", notify_irq, 1);
    chk("R4 no sig", notify_sig_wr, 0);
    step();
    chk("R4 pulse one cycle", notify_irq, 0);
    issue(2'b01, 4'd3);
    cpu_read_chk("R3 call kept", 2'd0, 16'd2);
    cpu_read_chk("R3 chan kept", 2'd1, 16'd7);
    cpu_write(2'd2, 16'd0);
    chk("R6 busy", task_busy, 1);
    cpu_write(2'd2, 16'd1);
    chk("R7 ack done", task_busy, 0);
    chk("R7 ack value", task_result, 1);
    cpu_write(2'd2, 16'h1234);
    chk("R8 result kept", task_result, 1);

    // R5 directed: signal mode, index 15, claim space
    cpu_write(2'd3, cfg_word(1'b1, 4'd15));
    issue(2'b01, 4'd0);
    chk("R5 sig", notify_sig_wr, 1);
    chk("R5 data", notify_sig_data, 15);
    chk("R5 no irq", notify_irq, 0);
    step();
    chk("R5 pulse one cycle", notify_sig_wr, 0);
    cpu_write(2'd2, 16'hFFFF);
    chk("R7 max ptr", task_result, 16'hFFFF);

    for (int i = 0; i < 150; i++) begin
      logic [PTR_W-1:0] p;
      p = PTR_W'($urandom);
      if (p == 0) p = 16'h0001;
      one_call(1'($urandom), TID_W'($urandom), 2'($urandom), CH_W'($urandom), p,
               bit'($urandom_range(0, 1)));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule